// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an asynchronous static memory of 262,144 words by 4 bits. On the user side there is a request/ready handshake that carries an 18-bit word address, a write flag and 4 bits of write data. A read returns its 4-bit result with a one-cycle valid strobe. On the memory side the block drives active-low chip enable, write enable and output enable, the address bus, and a shared data bus. The data bus is modelled as a separate output value, an output-enable for the controller's driver, and an input value.

Every phase on the memory pins is a whole number of clock cycles. These counts come from nanosecond timing parameters and the clock period: each time is rounded up, and each phase lasts at least one cycle. All pins are driven from registers, so they do not glitch. The controller keeps its own driver off whenever the memory may still be driving the bus. Around a write it keeps output enable inactive and waits out the memory's bus-release time. After a read it waits the same time again before it takes the next request.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the cycle after acceptance `req_ready` is low, so a request that stays asserted is taken only once.
- R2: A read first drives the request address for one cycle with all three strobes high. It then holds chip enable and output enable low with write enable high. On the last edge of that window it samples the data bus. `rd_valid` is high for exactly one cycle, the cycle in which output enable returns high, and `rd_data` carries the sampled word.
- R3: During a read, chip enable and output enable stay low for RD = max(ceil(T_RC/CLK_NS), ceil(T_AA/CLK_NS), ceil(T_OE/CLK_NS)) cycles.
- R4: During a write, chip enable and write enable stay low together for WP = max(ceil(T_WP/CLK_NS), ceil(T_DW/CLK_NS)) cycles. The controller drives the stored write data for the whole pulse, output enable stays high, and the word is stored at the given address.
- R5: Before the write pulse, the address is presented for HZ = ceil(T_HZ/CLK_NS) cycles. During these cycles all strobes are high and the controller's driver is off.
- R6: After write enable rises, the controller holds the address for WR = ceil(T_WR/CLK_NS) recovery cycles with all strobes high. `req_ready` returns in the cycle after these.
- R7: The controller's data driver is on only while write enable is low and output enable is high. The memory and the controller never drive the bus in the same cycle.
- R8: After a read, `req_ready` returns 1 + HZ cycles after output enable rises. This covers one cycle for the result and HZ cycles of bus turnaround.
- R9: While reset is held, all strobes are high, the driver is off, `rd_valid` is low and `req_ready` is high.
- R10: Write enable is never low while chip enable is high. Both fall on the same edge and both rise on the same edge.
- R11: Each timing parameter is converted by rounding up, and each phase lasts at least one cycle. With these counts every access meets the memory's minimum times for access, pulse width, data setup and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W | Read result |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DATA_W | Value the controller drives onto the data bus |
| sram_dq_oe | output | 1 | Controller data driver enable |
| sram_dq_in | input | DATA_W | Value seen on the data bus |

## Verification
The bench pairs the controller with a clocked memory model. The model returns unknown data until enough cycles of stable read conditions have passed, and it keeps driving the bus for HZ cycles after a read ends. It counts every cycle in which both sides drive the bus, every write pulse that is too short, every write whose data was not valid long enough, and every address that moves during recovery. A controller that captured read data one cycle early would return unknown values. One that turned on its driver right after a read would be counted as contention, and one that shortened the write pulse would store nothing and later read back stale data. The bench measures each strobe window and each ready gap at the pins against counts it works out from the nanosecond parameters. It reaches the highest address and address zero, all-zero and all-one data, and reads that follow straight after writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_DONE,
      ST_TURN,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER
   } ctrl_state_t;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drv;
   } pin_set_t;

   // nanoseconds to cycles, rounded up; zero stays zero
   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      return (t_ns <= 0) ? 0 : (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // strobe levels seen on the pins while a given state is current
   function automatic pin_set_t pins_for(input ctrl_state_t s);
      pin_set_t p;
      p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
      case (s)
         ST_RD_WAIT:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
         ST_WR_PULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
         default:     ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 2,
   parameter int HZ_CYC = 1,
   parameter int WR_CYC = 1,
   parameter int CNT_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             timer_zero,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output logic             idle,
   output logic             capture,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             drv
);

   localparam logic [CNT_W-1:0] L_RD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] L_WP = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] L_HZ = CNT_W'(HZ_CYC - 1);
   localparam logic [CNT_W-1:0] L_WR = CNT_W'(WR_CYC - 1);

   ctrl_state_t state_q, state_d;
   pin_set_t    pins_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
         ST_RD_SETUP:   state_d = ST_RD_WAIT;
         ST_RD_WAIT:    if (timer_zero) state_d = ST_RD_DONE;
         ST_RD_DONE:    state_d = ST_TURN;
         ST_TURN:       if (timer_zero) state_d = ST_IDLE;
         ST_WR_SETUP:   if (timer_zero) state_d = ST_WR_PULSE;
         ST_WR_PULSE:   if (timer_zero) state_d = ST_WR_RECOVER;
         ST_WR_RECOVER: if (timer_zero) state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      case (state_d)
         ST_RD_WAIT:    timer_val = L_RD;
         ST_TURN:       timer_val = L_HZ;
         ST_WR_SETUP:   timer_val = L_HZ;
         ST_WR_PULSE:   timer_val = L_WP;
         ST_WR_RECOVER: timer_val = L_WR;
         default:       timer_val = '0;
      endcase
   end

   assign timer_load = (state_d != state_q);
   assign capture    = (state_q == ST_RD_WAIT) && (state_d == ST_RD_DONE);
   assign idle       = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pins_q  <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
      end else begin
         state_q <= state_d;
         pins_q  <= pins_for(state_d);
      end
   end

   assign ce_n = pins_q.ce_n;
   assign we_n = pins_q.we_n;
   assign oe_n = pins_q.oe_n;
   assign drv  = pins_q.drv;

   // checker counters: length of the current low run of each strobe
   logic [7:0] oe_run, we_run;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_run <= '0;
         we_run <= '0;
      end else begin
         oe_run <= oe_n ? 8'd0 : ((oe_run == 8'hFF) ? oe_run : oe_run + 8'd1);
         we_run <= we_n ? 8'd0 : ((we_run == 8'hFF) ? we_run : we_run + 8'd1);
      end
   end

   p_rd_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> (oe_run == 8'(RD_CYC)));
   p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_run == 8'(WP_CYC)));
   p_single_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> (oe_n && !we_n));
   p_we_inside_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);
   p_ce_rises_with_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> ce_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 4,
   parameter int CLK_NS = 5,
   parameter int T_RC   = 7,
   parameter int T_AA   = 7,
   parameter int T_OE   = 4,
   parameter int T_WP   = 7,
   parameter int T_DW   = 4,
   parameter int T_WR   = 1,
   parameter int T_HZ   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int RD_CYC  = imax(1, imax(imax(ns_to_cyc(T_RC, CLK_NS), ns_to_cyc(T_AA, CLK_NS)),
                                         ns_to_cyc(T_OE, CLK_NS)));
   localparam int WP_CYC  = imax(1, imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS)));
   localparam int HZ_CYC  = imax(1, ns_to_cyc(T_HZ, CLK_NS));
   localparam int WR_CYC  = imax(1, ns_to_cyc(T_WR, CLK_NS));
   localparam int CNT_MAX = imax(imax(RD_CYC, WP_CYC), imax(HZ_CYC, WR_CYC));
   localparam int CNT_W   = imax(1, $clog2(CNT_MAX + 1));

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
      if (T_RC < 0 || T_AA < 0 || T_OE < 0 || T_WP < 0 || T_DW < 0 || T_WR < 0 || T_HZ < 0)
      begin : g_bad_time
         $error("timing parameters must not be negative");
      end
      if (CNT_MAX > 200) begin : g_bad_wait
         $error("wait count exceeds checker range");
      end
   endgenerate

   logic             timer_load, timer_zero, idle, capture, drv;
   logic [CNT_W-1:0] timer_val;

   sram_ctrl_fsm #(
      .RD_CYC (RD_CYC),
      .WP_CYC (WP_CYC),
      .HZ_CYC (HZ_CYC),
      .WR_CYC (WR_CYC),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .timer_zero (timer_zero),
      .timer_load (timer_load),
      .timer_val  (timer_val),
      .idle       (idle),
      .capture    (capture),
      .ce_n       (sram_ce_n),
      .we_n       (sram_we_n),
      .oe_n       (sram_oe_n),
      .drv        (drv)
   );

   sram_wait_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .zero     (timer_zero)
   );

   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              rvalid_q;

   assign accept = req_valid && idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture)
            rdata_q <= sram_dq_in;
         rvalid_q <= capture;
      end
   end

   assign req_ready   = idle;
   assign rd_valid    = rvalid_q;
   assign rd_data     = rdata_q;
   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign sram_dq_oe  = drv;

   p_take_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_rvalid_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (sram_oe_n && $past(!sram_oe_n)));
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> $stable(sram_addr));

endmodule

// File: tb/sram_behav_model.sv
module sram_behav_model #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 4,
   parameter int STORE_AW = 10,
   parameter int CLK_NS   = 5,
   parameter int T_AA     = 7,
   parameter int T_OE     = 4,
   parameter int T_WP     = 7,
   parameter int T_DW     = 4,
   parameter int T_WR     = 1,
   parameter int T_HZ     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ctrl_drv,
   output logic              drive,
   output logic [DATA_W-1:0] q,
   output int                contention_cnt,
   output int                viol_cnt
);

   localparam int DEPTH = 1 << STORE_AW;
   localparam int TAG_W = ADDR_W - STORE_AW;

   function automatic int up(input int t);
      return (t <= 0) ? 1 : (t + CLK_NS - 1) / CLK_NS;
   endfunction

   localparam int C_ACC = (up(T_AA) > up(T_OE)) ? up(T_AA) : up(T_OE);
   localparam int C_WP  = up(T_WP);
   localparam int C_DW  = up(T_DW);
   localparam int C_WR  = up(T_WR);
   localparam int C_HZ  = up(T_HZ);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [TAG_W-1:0]  tag [DEPTH];
   logic [DEPTH-1:0]  vld;

   logic              read_mode, wr_mode, rd_prev, wr_prev;
   logic [ADDR_W-1:0] last_addr, store_addr;
   logic [DATA_W-1:0] last_data;
   int                rd_cnt, wr_cnt, dat_cnt, hz_cnt, rec_cnt;
   logic [STORE_AW-1:0] idx;

   assign read_mode = !ce_n && !oe_n && we_n;
   assign wr_mode   = !ce_n && !we_n;
   assign idx       = addr[STORE_AW-1:0];
   assign drive     = read_mode || rd_prev || (hz_cnt != 0);

   always_comb begin
      if (read_mode && rd_cnt >= C_ACC - 1 && vld[idx] && tag[idx] == addr[ADDR_W-1:STORE_AW])
         q = mem[idx];
      else
         q = 'x;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld            <= '0;
         rd_prev        <= 1'b0;
         wr_prev        <= 1'b0;
         rd_cnt         <= 0;
         wr_cnt         <= 0;
         dat_cnt        <= 0;
         hz_cnt         <= 0;
         rec_cnt        <= 0;
         last_addr      <= '0;
         last_data      <= '0;
         store_addr     <= '0;
         contention_cnt <= 0;
         viol_cnt       <= 0;
      end else begin
         last_addr <= addr;
         last_data <= wdata;
         rd_prev   <= read_mode;
         wr_prev   <= wr_mode;
         rd_cnt    <= (read_mode && addr == last_addr) ? rd_cnt + 1 : 0;
         wr_cnt    <= (wr_mode && addr == last_addr) ? wr_cnt + 1 : 0;
         dat_cnt   <= (wr_mode && ctrl_drv && wdata == last_data) ? dat_cnt + 1 : 0;
         if (rd_prev && !read_mode)
            hz_cnt <= C_HZ - 1;
         else if (hz_cnt != 0)
            hz_cnt <= hz_cnt - 1;
         if (drive && ctrl_drv)
            contention_cnt <= contention_cnt + 1;
         if (wr_prev && !wr_mode) begin
            if (wr_cnt >= C_WP && dat_cnt >= C_DW) begin
               mem[idx] <= wdata;
               tag[idx] <= addr[ADDR_W-1:STORE_AW];
               vld[idx] <= 1'b1;
            end else begin
               viol_cnt <= viol_cnt + 1;
            end
            rec_cnt    <= 1;
            store_addr <= addr;
         end else if (rec_cnt != 0) begin
            if (rec_cnt < C_WR && addr != store_addr)
               viol_cnt <= viol_cnt + 1;
            rec_cnt <= (rec_cnt >= C_WR) ? 0 : rec_cnt + 1;
         end
      end
   end

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 18;
   localparam int DW  = 4;
   localparam int CNS = 3;
   localparam int TRC = 7, TAA = 7, TOE = 4, TWP = 7, TDW = 4, TWR = 1, THZ = 4;

   localparam int C_RC = (TRC + CNS - 1) / CNS;
   localparam int C_AA = (TAA + CNS - 1) / CNS;
   localparam int C_OE = (TOE + CNS - 1) / CNS;
   localparam int C_WP = (TWP + CNS - 1) / CNS;
   localparam int C_DW = (TDW + CNS - 1) / CNS;
   localparam int E_WR = (TWR + CNS - 1) / CNS;
   localparam int E_HZ = (THZ + CNS - 1) / CNS;
   localparam int E_RD0 = (C_RC > C_AA) ? C_RC : C_AA;
   localparam int E_RD  = (E_RD0 > C_OE) ? E_RD0 : C_OE;
   localparam int E_WP  = (C_WP > C_DW) ? C_WP : C_DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid, ce_n, we_n, oe_n, dq_oe, mem_drive;
   logic [DW-1:0] rd_data, dq_out, mem_q, dq_bus;
   logic [AW-1:0] sram_addr;
   int contention_cnt, viol_cnt;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CNS),
      .T_RC(TRC), .T_AA(TAA), .T_OE(TOE), .T_WP(TWP), .T_DW(TDW), .T_WR(TWR), .T_HZ(THZ)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
      .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n),
      .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_bus)
   );

   sram_behav_model #(
      .ADDR_W(AW), .DATA_W(DW), .STORE_AW(10), .CLK_NS(CNS),
      .T_AA(TAA), .T_OE(TOE), .T_WP(TWP), .T_DW(TDW), .T_WR(TWR), .T_HZ(THZ)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(sram_addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .wdata(dq_out), .ctrl_drv(dq_oe), .drive(mem_drive), .q(mem_q),
      .contention_cnt(contention_cnt), .viol_cnt(viol_cnt)
   );

   assign dq_bus = mem_drive ? mem_q : (dq_oe ? dq_out : 'z);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_q [$];
   logic [DW-1:0] ref_mem [logic [AW-1:0]];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // driver: pushes expected read results in request order
   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #2;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) begin @(posedge clk); #2; end
      if (wr) ref_mem[a] = d;
      else exp_q.push_back(ref_mem[a]);
      @(posedge clk); #2;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // monitor: scoreboard and pin-phase measurements
   int oe_run = 0, we_run = 0, rd_gap = 0, wr_gap = 0, su = 0;
   bit after_rd = 0, after_wr = 0, track = 0, track_wr = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            if (exp_q.size() == 0)
               check(1'b0, "R2 unexpected rd_valid", 32'(rd_data), 32'hFFFF);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               check(rd_data === e, "R2 read data", 32'(rd_data), 32'(e));
            end
         end
         if (!oe_n) begin
            oe_run++;
            check(ce_n == 0 && we_n == 1 && dq_oe == 0, "R2 read strobes", {ce_n, we_n, dq_oe}, 32'b010);
         end else if (oe_run != 0) begin
            check(oe_run == E_RD, "R3 read window", oe_run, E_RD);
            check(rd_valid == 1'b1, "R2 rd_valid position", 32'(rd_valid), 1);
            oe_run = 0; after_rd = 1; rd_gap = 0;
         end
         if (after_rd) begin
            if (req_ready) begin
               check(rd_gap == 1 + E_HZ, "R8 read turnaround", rd_gap, 1 + E_HZ);
               after_rd = 0;
            end else rd_gap++;
         end
         if (!we_n) begin
            we_run++;
            check(ce_n == 0 && oe_n == 1 && dq_oe == 1, "R10 R7 write strobes", {ce_n, oe_n, dq_oe}, 32'b011);
         end else begin
            if (we_run != 0) begin
               check(we_run == E_WP, "R4 write pulse", we_run, E_WP);
               check(ce_n == 1'b1, "R10 ce rises with we", 32'(ce_n), 1);
               we_run = 0; after_wr = 1; wr_gap = 0;
            end
            if (dq_oe) check(1'b0, "R7 driver outside pulse", 1, 0);
         end
         if (after_wr) begin
            if (req_ready) begin
               check(wr_gap == E_WR, "R6 write recovery", wr_gap, E_WR);
               after_wr = 0;
            end else begin
               check(sram_addr == req_addr_hist, "R6 address held", 32'(sram_addr), 32'(req_addr_hist));
               wr_gap++;
            end
         end
         if (track) begin
            if (su == 0) check(req_ready == 1'b0, "R1 ready drops", 32'(req_ready), 0);
            if (track_wr) begin
               if (!we_n) begin
                  check(su == E_HZ, "R5 write setup", su, E_HZ);
                  track = 0;
               end else begin
                  check(ce_n && oe_n && !dq_oe && sram_addr == req_addr_hist, "R5 setup pins",
                        {ce_n, oe_n, dq_oe}, 32'b110);
                  su++;
               end
            end else begin
               if (!oe_n) begin
                  check(su == 1 && sram_addr == req_addr_hist, "R2 read setup", su, 1);
                  track = 0;
               end else su++;
            end
         end
         if (req_valid && req_ready) begin
            track = 1; track_wr = req_write; su = 0; req_addr_hist = req_addr;
         end
      end
   end

   logic [AW-1:0] req_addr_hist = '0;

   function automatic logic [AW-1:0] addr_of(input int k);
      logic [7:0] hi;
      logic [9:0] lo;
      hi = 8'((k * 29 + 3) & 255);
      lo = 10'(2 * k + 2);
      return {hi, lo};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(ce_n && we_n && oe_n, "R9 strobes in reset", {ce_n, we_n, oe_n}, 32'b111);
      check(!dq_oe && !rd_valid, "R9 driver and valid in reset", {dq_oe, rd_valid}, 0);
      check(req_ready, "R9 ready in reset", 32'(req_ready), 1);
      @(posedge clk); #2; rst_n = 1'b1;
      @(negedge clk);
      check(ce_n && we_n && oe_n && !dq_oe && req_ready, "R9 state after reset",
            {ce_n, we_n, oe_n, dq_oe, req_ready}, 32'b11101);

      // corners of address and data
      issue(1, '0, 4'h0);
      issue(1, {AW{1'b1}}, 4'hF);
      issue(0, {AW{1'b1}}, 4'h0);
      issue(0, '0, 4'h0);
      // fill with alternating patterns (R11: every write meets limits)
      for (int k = 0; k < 24; k++) issue(1, addr_of(k), (k % 2) ? 4'h5 : 4'hA);
      for (int k = 0; k < 24; k++) issue(0, addr_of(k), 4'h0);
      // write then immediate read of same word, read then write
      for (int k = 0; k < 12; k++) begin
         issue(1, addr_of(k), 4'(k * 7 + 1));
         issue(0, addr_of(k), 4'h0);
         issue(0, addr_of(k + 12), 4'h0);
      end
      // overwrite and back-to-back reads
      issue(1, addr_of(3), 4'hC);
      issue(1, addr_of(3), 4'h3);
      issue(0, addr_of(3), 4'h0);
      issue(0, addr_of(3), 4'h0);
      issue(0, {AW{1'b1}}, 4'h0);

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
      check(contention_cnt == 0, "R7 bus contention cycles", contention_cnt, 0);
      check(viol_cnt == 0, "R11 memory timing violations", viol_cnt, 0);
      check(E_WR == 1 && E_HZ == 2 && E_RD == 3 && E_WP == 3, "R11 cycle conversion",
            {E_RD[7:0], E_WP[7:0], E_HZ[7:0], E_WR[7:0]}, 32'h03030201);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule